// File: doc/BRIEF.md
# Configurable Operand Register Bank

This block holds the integer registers of a small multicycle core. It returns two 32-bit source operands for each fetch request and accepts one register write per clock. The caller raises `fetch_req` for one cycle with two source indices. The block then pulses `opnd_valid` once both operands are on `opnd_a` and `opnd_b`. The operands stay unchanged until the next request.

Two build parameters set cost against speed. `DUAL_READ` picks either two read ports, which answer in one cycle, or one shared read port. With the shared port the second operand is read one cycle after the first, so the answer takes two cycles. `FULL_SET` picks 32 registers, or 16 registers in which the top index bit is ignored. In the 16-register build, indices 16..31 alias onto 0..15 and raise no error. Register-immediate users only need `opnd_a`, which the shared-port build also captures in the first cycle.

Top module: `opnd_regbank`

## Requirements
- R1: With `DUAL_READ`=1, `opnd_valid` is high in the cycle after a `fetch_req` cycle. `opnd_a` and `opnd_b` hold the registers selected by `fetch_ra` and `fetch_rb`, both read at that request edge.
- R2: With `DUAL_READ`=0, `opnd_valid` is low in the cycle after a request and high in the cycle after that. `opnd_a` is read at the request edge and `opnd_b` at the following edge. No request may be raised in the cycle right after a request.
- R3: When no request is raised, `opnd_a` is unchanged in the next cycle. `opnd_b` is unchanged as well, except at the second read edge of the shared-port build. `opnd_valid` falls after its one-cycle pulse.
- R4: A read of register 0 returns zero on either operand, whatever has been written to index 0.
- R5: A write whose effective index is 0 is discarded.
- R6: With `FULL_SET`=0 only the low four index bits select a register, so index 16+k reaches register k for reads and writes, and no error is signalled.
- R7: A read and a write of the same register at the same edge return the value held before the write (no bypass).
- R8: With `wr_en` high at a clock edge, `wr_data` is stored in the register at `wr_idx`. Reads at later edges return it.
- R9: Synchronous active-low reset clears `opnd_valid`, `opnd_a`, `opnd_b` and the read sequencing. Register contents are not reset.
- R10: With `wr_en` low, no register changes, whatever `wr_idx` and `wr_data` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | input | 1 | Start an operand fetch (one-cycle pulse) |
| fetch_ra | input | IDX_W | Index of the first source register |
| fetch_rb | input | IDX_W | Index of the second source register |
| opnd_valid | output | 1 | One-cycle pulse when both operands are ready |
| opnd_a | output | DATA_W | First operand, held until the next request |
| opnd_b | output | DATA_W | Second operand, held until the next request |
| wr_en | input | 1 | Write enable |
| wr_idx | input | IDX_W | Write register index |
| wr_data | input | DATA_W | Write data |

## Verification
The assertions assume that a shared-port build never sees a request in the cycle right after a request. They also assume that no register is read before it has been written, and that no write is issued while reset is held. The stimulus first writes all 32 indices. It then spaces requests at least two idle cycles apart, even in the mixed read/write sweep that drives both builds from the same inputs. Writes occur only after reset is released.

// File: rtl/regbank_pkg.sv
// Shared types for the operand register bank.
package regbank_pkg;
    // Read phase of the shared-port sequencer.
    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_SECOND = 1'b1
    } fetch_ph_e;
endpackage

// File: rtl/regbank_store.sv
// Register storage with one write port and NUM_RD combinational read ports.
// Assumes NUM_REGS is a power of two. Index bits above log2(NUM_REGS) are
// dropped, so wider indices alias. Effective index 0 reads as zero, and
// writes to it are discarded. Contents are not reset.
module regbank_store #(
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 5,
    parameter int NUM_REGS = 32,
    parameter int NUM_RD   = 2
) (
    input  logic                           clk,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [NUM_RD-1:0][IDX_W-1:0]   rd_idx,
    output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data
);
    localparam int SEL_W = $clog2(NUM_REGS);

    logic [DATA_W-1:0] mem [NUM_REGS];
    logic [SEL_W-1:0]  wr_sel;

    assign wr_sel = SEL_W'(wr_idx % NUM_REGS);

    // Store the write data unless the target is the zero register.
    always_ff @(posedge clk) begin
        if (wr_en && wr_sel != '0) begin
            mem[wr_sel] <= wr_data;
        end
    end

    // One read mux per port, with the zero register forced to zero.
    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        logic [SEL_W-1:0] rd_sel;
        assign rd_sel     = SEL_W'(rd_idx[g] % NUM_REGS);
        assign rd_data[g] = (rd_sel == '0) ? '0 : mem[rd_sel];
    end
endmodule

// File: rtl/regbank_seq.sv
// Operand fetch sequencer. DUAL=1 captures both operands at the request edge.
// DUAL=0 time-shares one read port: first operand at the request edge,
// second operand one edge later. Assumes no request arrives while the
// second read is pending.
module regbank_seq
    import regbank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    parameter bit DUAL   = 1'b1,
    localparam int NUM_RD = DUAL ? 2 : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           fetch_req,
    input  logic [IDX_W-1:0]               fetch_ra,
    input  logic [IDX_W-1:0]               fetch_rb,
    output logic [NUM_RD-1:0][IDX_W-1:0]   rd_idx,
    input  logic [NUM_RD-1:0][DATA_W-1:0]  rd_data,
    output logic                           opnd_valid,
    output logic [DATA_W-1:0]              opnd_a,
    output logic [DATA_W-1:0]              opnd_b
);
    if (DUAL) begin : g_dual
        assign rd_idx[0] = fetch_ra;
        assign rd_idx[1] = fetch_rb;

        // Capture both operands at the request edge and pulse valid once.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                opnd_valid <= 1'b0;
                opnd_a     <= '0;
                opnd_b     <= '0;
            end else begin
                opnd_valid <= fetch_req;
                if (fetch_req) begin
                    opnd_a <= rd_data[0];
                    opnd_b <= rd_data[1];
                end
            end
        end

        assert_dual_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
            fetch_req |=> opnd_valid);
    end else begin : g_single
        fetch_ph_e        ph;
        logic [IDX_W-1:0] pend_rb;

        assign rd_idx[0] = (ph == PH_SECOND) ? pend_rb : fetch_ra;

        // Step through the two reads on the shared port and pulse valid at the end.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ph         <= PH_IDLE;
                pend_rb    <= '0;
                opnd_valid <= 1'b0;
                opnd_a     <= '0;
                opnd_b     <= '0;
            end else if (ph == PH_SECOND) begin
                opnd_b     <= rd_data[0];
                opnd_valid <= 1'b1;
                ph         <= PH_IDLE;
            end else begin
                opnd_valid <= 1'b0;
                if (fetch_req) begin
                    opnd_a  <= rd_data[0];
                    pend_rb <= fetch_rb;
                    ph      <= PH_SECOND;
                end
            end
        end

        assert_single_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
            fetch_req |=> !opnd_valid ##1 opnd_valid);
        assert_no_req_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (ph == PH_SECOND) |-> !fetch_req);
    end
endmodule

// File: rtl/opnd_regbank.sv
// Top of the operand register bank: storage plus fetch sequencer.
// DUAL_READ picks two read ports or one shared port. FULL_SET picks
// 2**IDX_W registers or half as many, with the top index bit ignored.
module opnd_regbank #(
    parameter bit DUAL_READ = 1'b1,
    parameter bit FULL_SET  = 1'b1,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [IDX_W-1:0]  fetch_ra,
    input  logic [IDX_W-1:0]  fetch_rb,
    output logic              opnd_valid,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int NUM_REGS = FULL_SET ? (2 ** IDX_W) : (2 ** (IDX_W - 1));
    localparam int NUM_RD   = DUAL_READ ? 2 : 1;

    logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx;
    logic [NUM_RD-1:0][DATA_W-1:0] rd_data;

    regbank_store #(
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W),
        .NUM_REGS (NUM_REGS),
        .NUM_RD   (NUM_RD)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    regbank_seq #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .DUAL   (DUAL_READ)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_req  (fetch_req),
        .fetch_ra   (fetch_ra),
        .fetch_rb   (fetch_rb),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .opnd_valid (opnd_valid),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b)
    );

    assert_zero_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && (fetch_ra % NUM_REGS) == 0) |=> (opnd_a == '0));
    assert_hold_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req |=> $stable(opnd_a));
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (!opnd_valid && opnd_a == '0 && opnd_b == '0));
endmodule

// File: tb/opnd_regbank_bench.sv
// Bench: drives a dual-port 32-register build and a shared-port 16-register
// build with the same inputs, and compares each against a behavioural model
// on every clock.
module opnd_regbank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [4:0]  ra = '0, rb = '0, widx = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;

    logic        v_d, v_s;
    logic [31:0] a_d, b_d, a_s, b_s;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cyc     = 0;
    bit    armed   = 1'b0;
    string tag     = "R9";

    always #2.5 clk = ~clk;

    opnd_regbank #(.DUAL_READ(1'b1), .FULL_SET(1'b1)) u_opnd_regbank (
        .clk(clk), .rst_n(rst_n), .fetch_req(req), .fetch_ra(ra), .fetch_rb(rb),
        .opnd_valid(v_d), .opnd_a(a_d), .opnd_b(b_d),
        .wr_en(we), .wr_idx(widx), .wr_data(wdata));

    opnd_regbank #(.DUAL_READ(1'b0), .FULL_SET(1'b0)) u_opnd_regbank_sp (
        .clk(clk), .rst_n(rst_n), .fetch_req(req), .fetch_ra(ra), .fetch_rb(rb),
        .opnd_valid(v_s), .opnd_a(a_s), .opnd_b(b_s),
        .wr_en(we), .wr_idx(widx), .wr_data(wdata));

    // Reference model state
    logic [31:0] ref32 [32];
    logic [31:0] ref16 [16];
    logic        ev_d = 0, ev_s = 0, pend = 0;
    logic [31:0] ea_d = 0, eb_d = 0, ea_s = 0, eb_s = 0;
    int          pend_rb = 0;

    function automatic logic [31:0] rd32(int i);
        return (i == 0) ? 32'h0 : ref32[i];
    endfunction
    function automatic logic [31:0] rd16(int i);
        return ((i % 16) == 0) ? 32'h0 : ref16[i % 16];
    endfunction

    // Model: read old contents first, then apply the write (R7, R8, R5, R6, R10).
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            ev_d = 0; ea_d = 0; eb_d = 0;
            ev_s = 0; ea_s = 0; eb_s = 0; pend = 0;
        end else begin
            ev_d = req;
            if (req) begin ea_d = rd32(int'(ra)); eb_d = rd32(int'(rb)); end
            if (pend) begin
                eb_s = rd16(pend_rb); ev_s = 1; pend = 0;
            end else begin
                ev_s = 0;
                if (req) begin ea_s = rd16(int'(ra)); pend_rb = int'(rb); pend = 1; end
            end
        end
        if (we) begin
            if (widx != 0) ref32[widx] = wdata;
            if (widx[3:0] != 0) ref16[widx[3:0]] = wdata;
        end
        armed = 1'b1;
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Compare both builds against the model away from the active edge.
    always @(negedge clk) begin
        if (armed) begin
            chk("dual valid", {31'b0, v_d}, {31'b0, ev_d});
            chk("dual a", a_d, ea_d);
            chk("dual b", b_d, eb_d);
            chk("single valid", {31'b0, v_s}, {31'b0, ev_s});
            chk("single a", a_s, ea_s);
            chk("single b", b_s, eb_s);
        end
    end

    task automatic fetch(input logic [4:0] x, input logic [4:0] y);
        @(negedge clk); req = 1; ra = x; rb = y;
        @(negedge clk); req = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hang counts as a failure and still prints the summary.
    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog act=%0d exp<=20000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) ref32[i] = 0;
        for (int i = 0; i < 16; i++) ref16[i] = 0;
        // R9: reset state of both builds
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R8 / R5 / R6: fill every index, including 0 and the aliased upper half
        tag = "R8";
        for (int i = 0; i < 32; i++) begin
            @(negedge clk); we = 1; widx = 5'(i); wdata = 32'hA500_0000 + 32'(i * 32'h0101);
        end
        @(negedge clk); we = 0;
        @(negedge clk);
        tag = "R4"; fetch(5'd0, 5'd0);
        fetch(5'd16, 5'd0);
        tag = "R5"; @(negedge clk); we = 1; widx = 0; wdata = 32'hFFFF_FFFF;
        @(negedge clk); we = 1; widx = 5'd16; wdata = 32'hDEAD_BEEF;
        @(negedge clk); we = 0;
        fetch(5'd0, 5'd16);
        tag = "R6"; fetch(5'd17, 5'd5);
        fetch(5'd21, 5'd31);
        tag = "R7";
        @(negedge clk); req = 1; ra = 5'd3; rb = 5'd4; we = 1; widx = 5'd3; wdata = 32'h1234_5678;
        @(negedge clk); req = 0; we = 1; widx = 5'd4; wdata = 32'h8765_4321;
        @(negedge clk); we = 0;
        @(negedge clk);
        fetch(5'd3, 5'd4);
        tag = "R10";
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); we = 0; widx = 5'(i + 6); wdata = 32'hBAD0_0000 + 32'(i);
        end
        fetch(5'd6, 5'd7);
        fetch(5'd8, 5'd9);
        tag = "R3"; repeat (5) @(negedge clk);
        tag = "R1";
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            we = (i % 3) != 0; widx = 5'((i * 7 + 3) % 32);
            wdata = 32'h1000_0000 ^ 32'(i * 40503);
            req = (i % 3) == 0; ra = 5'((i * 5) % 32); rb = 5'((i * 11 + 1) % 32);
            tag = (i % 2) ? "R1" : "R2";
        end
        @(negedge clk); req = 0; we = 0;
        repeat (3) @(negedge clk);
        tag = "R9";
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        tag = "R2"; fetch(5'd9, 5'd12);
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule